// File: doc/BRIEF.md
# Conditional Branch Target Resolver

This block resolves the program-counter-relative branches of an 8-bit processor core with a 16-bit address space per bank. It receives the branch opcode, the four condition flags (negative, overflow, zero, carry), the address of the instruction that follows the branch, the current bank byte and the displacement bytes. From these it decides whether the branch is taken and computes the next program counter. The bank byte is passed through unchanged.

Three families are handled. The first is eight flag-tested short branches. The second is an unconditional short branch. The third is an unconditional long branch whose 16-bit offset reaches any address in the current 64K bank. Any other opcode is reported as invalid. All results are registered, so they appear one clock after the inputs are presented. The fetch unit supplies the displacement bytes and the sequential address. The sequencer uses the taken flag, the target and the length.

Top module: `brt_resolver`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is cleared to zero after that edge.
- R2: A conditional branch opcode has bits [4:0] = 10000. Bits [7:6] pick the flag: 00 negative, 01 overflow, 10 carry, 11 zero. Bit 5 is the flag value that makes the branch taken. This gives 0x10 (n=0), 0x30 (n=1), 0x50 (v=0), 0x70 (v=1), 0x90 (c=0), 0xB0 (c=1), 0xD0 (z=0) and 0xF0 (z=1).
- R3: A taken short branch reports `taken`=1 and `insn_len`=2. Its `next_pc` is `seq_pc` plus `disp_lo`, where `disp_lo` is sign-extended from 8 to 16 bits.
- R4: A conditional branch whose condition is false reports `taken`=0, `insn_len`=2 and `next_pc` = `seq_pc`.
- R5: Opcode 0x80 is always taken, whatever the flags are. It uses the short displacement of R3 and has `insn_len`=2.
- R6: Opcode 0x82 is always taken, with `insn_len`=3. Its offset is the 16-bit two's-complement value {`disp_hi`, `disp_lo`}, with the low byte coming first in the instruction stream. It is added to `seq_pc`.
- R7: The target addition wraps modulo 65536 in both directions.
- R8: `next_bank` equals `bank_in` for every opcode.
- R9: Any opcode other than the ten listed in R2, R5 and R6 reports `invalid`=1, `taken`=0, `insn_len`=0 and `next_pc` = `seq_pc`.
- R10: For short branches, `disp_hi` has no effect on any output.
- R11: Outputs change only at a rising clock edge. They reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 8 | Opcode of the instruction being resolved |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| seq_pc | input | 16 | Address of the instruction following the branch |
| bank_in | input | 8 | Current program bank |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte (long branch only) |
| taken | output | 1 | Branch is taken |
| invalid | output | 1 | Opcode is not a relative branch |
| insn_len | output | 2 | Instruction length in bytes (0 when invalid) |
| next_pc | output | 16 | Next program counter |
| next_bank | output | 8 | Bank for the next fetch |

## Verification
The assertions assume that `seq_pc` already accounts for the length of the instruction being resolved. They also assume that every input is held stable over the rising edge that samples it. Both can be checked only in relation to the previous sampled value. The bench changes inputs only on falling edges. It computes each expected target from an explicit per-opcode table and from its own sign extension. It picks addresses near 0x0000 and 0xFFFF so that both wrap directions are exercised.

// File: rtl/brt_pkg.sv
// Shared types for the branch resolver.
// Assumes opcodes are 8 bits and flags are the four condition bits n, v, z, c.
package brt_pkg;
    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_COND  = 2'd1,
        BK_SHORT = 2'd2,
        BK_LONG  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam logic [7:0] OP_ALWAYS_SHORT = 8'h80;
    localparam logic [7:0] OP_ALWAYS_LONG  = 8'h82;
    localparam logic [4:0] COND_LOW_BITS   = 5'b10000;
endpackage

// File: rtl/brt_decode.sv
// Classifies an opcode into a branch kind and evaluates its condition.
// Assumes the conditional family shares a fixed low-bit pattern, with the
// flag picked by the two top bits and the wanted value given by bit 5.
module brt_decode
    import brt_pkg::*;
(
    input  logic [7:0] opcode,
    input  flags_t     flags,
    output br_kind_e   kind,
    output logic       cond_met
);
    logic sel_flag;

    // Map the opcode to its branch family.
    always_comb begin
        if (opcode[4:0] == COND_LOW_BITS)  kind = BK_COND;
        else if (opcode == OP_ALWAYS_SHORT) kind = BK_SHORT;
        else if (opcode == OP_ALWAYS_LONG)  kind = BK_LONG;
        else                                kind = BK_NONE;
    end

    // Pick the flag tested by a conditional opcode.
    always_comb begin
        case (opcode[7:6])
            2'b00:   sel_flag = flags.n;
            2'b01:   sel_flag = flags.v;
            2'b10:   sel_flag = flags.c;
            default: sel_flag = flags.z;
        endcase
    end

    // Decide whether the branch is taken for each kind.
    always_comb begin
        case (kind)
            BK_COND:  cond_met = (sel_flag == opcode[5]);
            BK_SHORT: cond_met = 1'b1;
            BK_LONG:  cond_met = 1'b1;
            default:  cond_met = 1'b0;
        endcase
    end
endmodule

// File: rtl/brt_target.sv
// Computes the relative target and picks the next PC.
// Assumes seq_pc is the address after the whole branch instruction. Short
// offsets are sign-extended and long offsets are {hi, lo}. The sum wraps.
module brt_target
    import brt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  br_kind_e            kind,
    input  logic                cond_met,
    input  logic [ADDR_W-1:0]   seq_pc,
    input  logic [DISP_W-1:0]   disp_lo,
    input  logic [DISP_W-1:0]   disp_hi,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [1:0]          len_out
);
    localparam int LONG_W = 2 * DISP_W;

    logic [ADDR_W-1:0] short_off;
    logic [ADDR_W-1:0] long_off;
    logic [LONG_W-1:0] long_raw;
    logic [ADDR_W-1:0] offset;

    assign long_raw  = {disp_hi, disp_lo};
    assign short_off = {{(ADDR_W-DISP_W){disp_lo[DISP_W-1]}}, disp_lo};

    // Fit the long offset to the address width.
    generate
        if (ADDR_W > LONG_W) begin : g_long_ext
            assign long_off = {{(ADDR_W-LONG_W){long_raw[LONG_W-1]}}, long_raw};
        end else if (ADDR_W == LONG_W) begin : g_long_eq
            assign long_off = long_raw;
        end else begin : g_long_trunc
            assign long_off = long_raw[ADDR_W-1:0];
        end
    endgenerate

    // Choose the offset and form the next PC with modular addition.
    always_comb begin
        offset = (kind == BK_LONG) ? long_off : short_off;
        pc_out = cond_met ? (seq_pc + offset) : seq_pc;
    end

    // Instruction length per kind.
    always_comb begin
        case (kind)
            BK_LONG:          len_out = 2'd3;
            BK_COND, BK_SHORT: len_out = 2'd2;
            default:          len_out = 2'd0;
        endcase
    end
endmodule

// File: rtl/brt_resolver.sv
// Top of the branch resolver: decode, target computation, output register.
// Assumes inputs are stable around each rising edge. Results have a latency
// of one cycle and are cleared by a synchronous active-low reset.
module brt_resolver
    import brt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        opcode,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [DISP_W-1:0] disp_lo,
    input  logic [DISP_W-1:0] disp_hi,
    output logic              taken,
    output logic              invalid,
    output logic [1:0]        insn_len,
    output logic [ADDR_W-1:0] next_pc,
    output logic [BANK_W-1:0] next_bank
);
    flags_t            flags;
    br_kind_e          kind;
    logic              cond_met;
    logic [ADDR_W-1:0] pc_comb;
    logic [1:0]        len_comb;

    assign flags = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

    brt_decode u_decode (
        .opcode   (opcode),
        .flags    (flags),
        .kind     (kind),
        .cond_met (cond_met)
    );

    brt_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
        .kind     (kind),
        .cond_met (cond_met),
        .seq_pc   (seq_pc),
        .disp_lo  (disp_lo),
        .disp_hi  (disp_hi),
        .pc_out   (pc_comb),
        .len_out  (len_comb)
    );

    // Register every result. Synchronous reset clears all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken     <= 1'b0;
            invalid   <= 1'b0;
            insn_len  <= 2'd0;
            next_pc   <= '0;
            next_bank <= '0;
        end else begin
            taken     <= cond_met;
            invalid   <= (kind == BK_NONE);
            insn_len  <= len_comb;
            next_pc   <= pc_comb;
            next_bank <= bank_in;
        end
    end

    // R5: the always-short opcode is taken with length 2.
    p_always_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ALWAYS_SHORT) |=> (taken && insn_len == 2'd2));

    // R6: the long opcode is taken with length 3.
    p_long_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ALWAYS_LONG) |=> (taken && insn_len == 2'd3));

    // R8: the bank passes through one cycle later.
    p_bank_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (next_bank == $past(bank_in)));

    // R9: an invalid opcode never reports a taken branch or a length.
    p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (!taken && insn_len == 2'd0));

    // R4: a failed condition falls through to the sequential address.
    p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_COND && !cond_met) |=>
            (!taken && next_pc == $past(seq_pc) && insn_len == 2'd2));

    // R11: outputs hold when the registered inputs did not change.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(opcode) && $stable(seq_pc) && $stable(flags) &&
         $stable(disp_lo) && $stable(disp_hi) && $stable(bank_in) &&
         $past(rst_n)) |=> $stable(next_pc));
endmodule

// File: tb/tb_brt_resolver.sv
`timescale 1ns/1ps
module tb_brt_resolver;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  opcode;
    logic        flag_n, flag_v, flag_z, flag_c;
    logic [15:0] seq_pc;
    logic [7:0]  bank_in, disp_lo, disp_hi;
    logic        taken, invalid;
    logic [1:0]  insn_len;
    logic [15:0] next_pc;
    logic [7:0]  next_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    brt_resolver dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .seq_pc(seq_pc), .bank_in(bank_in), .disp_lo(disp_lo), .disp_hi(disp_hi),
        .taken(taken), .invalid(invalid), .insn_len(insn_len),
        .next_pc(next_pc), .next_bank(next_bank)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent table of the conditional opcodes.
    function automatic bit cond_taken(input logic [7:0] op, input logic [3:0] nvzc);
        case (op)
            8'h10: return !nvzc[3];
            8'h30: return  nvzc[3];
            8'h50: return !nvzc[2];
            8'h70: return  nvzc[2];
            8'hD0: return !nvzc[1];
            8'hF0: return  nvzc[1];
            8'h90: return !nvzc[0];
            8'hB0: return  nvzc[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic [7:0] op, input logic [3:0] nvzc,
                         input logic [15:0] pc, input logic [7:0] bank,
                         input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        opcode = op; {flag_n, flag_v, flag_z, flag_c} = nvzc;
        seq_pc = pc; bank_in = bank; disp_lo = lo; disp_hi = hi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic exp_taken,
                              input logic exp_inv, input logic [1:0] exp_len,
                              input logic [15:0] exp_pc);
        check(req, "taken",    taken,    exp_taken);
        check(req, "invalid",  invalid,  exp_inv);
        check(req, "insn_len", insn_len, exp_len);
        check(req, "next_pc",  next_pc,  exp_pc);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        opcode = 8'h80; {flag_n, flag_v, flag_z, flag_c} = 4'hF;
        seq_pc = 16'h1234; bank_in = 8'h56; disp_lo = 8'h10; disp_hi = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R1", "next_bank", next_bank, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_conditions_r2();
        logic [7:0] ops [8] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < 16; f += 5) begin
                bit t;
                t = cond_taken(ops[i], f[3:0]);
                drive(ops[i], f[3:0], 16'h4000, 8'h01, 8'h08, 8'h00);
                // R2 selection; R3 taken target; R4 fall-through
                expect_out(t ? "R3" : "R4", t, 1'b0, 2'd2, t ? 16'h4008 : 16'h4000);
                check("R2", "taken", taken, t);
            end
        end
    endtask

    task automatic t_short_disp_r3();
        drive(8'hF0, 4'b0010, 16'h1000, 8'h00, 8'h7F, 8'h00);
        expect_out("R3", 1'b1, 1'b0, 2'd2, 16'h107F);
        drive(8'h90, 4'b0000, 16'h1000, 8'h00, 8'h80, 8'h00);
        expect_out("R3", 1'b1, 1'b0, 2'd2, 16'h0F80);
        drive(8'h30, 4'b1000, 16'h1000, 8'h00, 8'hFF, 8'h00);
        expect_out("R3", 1'b1, 1'b0, 2'd2, 16'h0FFF);
    endtask

    task automatic t_always_short_r5();
        for (int f = 0; f < 16; f += 3) begin
            drive(8'h80, f[3:0], 16'h2000, 8'h00, 8'hF6, 8'h00);
            expect_out("R5", 1'b1, 1'b0, 2'd2, 16'h1FF6);
        end
    endtask

    task automatic t_long_r6();
        drive(8'h82, 4'h0, 16'h2000, 8'h00, 8'h00, 8'h80);
        expect_out("R6", 1'b1, 1'b0, 2'd3, 16'hA000);
        drive(8'h82, 4'hF, 16'h1234, 8'h00, 8'hFE, 8'hFF);
        expect_out("R6", 1'b1, 1'b0, 2'd3, 16'h1232);
        drive(8'h82, 4'h5, 16'h0100, 8'h00, 8'h34, 8'h12);
        expect_out("R6", 1'b1, 1'b0, 2'd3, 16'h1334);
    endtask

    task automatic t_wrap_r7();
        drive(8'h80, 4'h0, 16'hFFF0, 8'h00, 8'h20, 8'h00);
        expect_out("R7", 1'b1, 1'b0, 2'd2, 16'h0010);
        drive(8'hB0, 4'b0001, 16'h0005, 8'h00, 8'hF0, 8'h00);
        expect_out("R7", 1'b1, 1'b0, 2'd2, 16'hFFF5);
        drive(8'h82, 4'h0, 16'hF000, 8'h00, 8'h00, 8'h20);
        expect_out("R7", 1'b1, 1'b0, 2'd3, 16'h1000);
    endtask

    task automatic t_bank_r8();
        drive(8'h82, 4'h0, 16'hFFFF, 8'hA5, 8'h01, 8'h00);
        check("R8", "next_bank", next_bank, 8'hA5);
        check("R8", "next_pc",   next_pc,   16'h0000);
        drive(8'h4C, 4'h0, 16'h0001, 8'h3C, 8'h00, 8'h00);
        check("R8", "next_bank", next_bank, 8'h3C);
    endtask

    task automatic t_invalid_r9();
        logic [7:0] bad [5] = '{8'h00, 8'h4C, 8'h91, 8'hA0, 8'h81};
        for (int i = 0; i < 5; i++) begin
            drive(bad[i], 4'hF, 16'h5555, 8'h00, 8'h10, 8'h10);
            expect_out("R9", 1'b0, 1'b1, 2'd0, 16'h5555);
        end
    endtask

    task automatic t_hi_ignored_r10();
        drive(8'h80, 4'h0, 16'h3000, 8'h00, 8'h40, 8'h00);
        expect_out("R10", 1'b1, 1'b0, 2'd2, 16'h3040);
        drive(8'h80, 4'h0, 16'h3000, 8'h00, 8'h40, 8'hFF);
        expect_out("R10", 1'b1, 1'b0, 2'd2, 16'h3040);
        drive(8'hD0, 4'h0, 16'h3000, 8'h00, 8'hC0, 8'h7F);
        expect_out("R10", 1'b1, 1'b0, 2'd2, 16'h2FC0);
    endtask

    task automatic t_latency_r11();
        drive(8'h80, 4'h0, 16'h6000, 8'h00, 8'h02, 8'h00);
        @(negedge clk);
        opcode = 8'h82; seq_pc = 16'h7000; disp_lo = 8'h00; disp_hi = 8'h01;
        #2;
        check("R11", "next_pc before edge", next_pc, 16'h6002);
        check("R11", "insn_len before edge", insn_len, 2'd2);
        @(posedge clk);
        @(negedge clk);
        check("R11", "next_pc after edge", next_pc, 16'h7100);
        check("R11", "insn_len after edge", insn_len, 2'd3);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_conditions_r2();
        t_short_disp_r3();
        t_always_short_r5();
        t_long_r6();
        t_wrap_r7();
        t_bank_r8();
        t_invalid_r9();
        t_hi_ignored_r10();
        t_latency_r11();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule